// File: doc/BRIEF.md
# E-paper panel bring-up and refresh sequencer

This block runs the fixed control sequences for an e-paper panel that is driven by two display controllers. A pulse on one start input runs the bring-up sequence. It toggles the panel's active-low hardware reset line, waits for the panel, and then sends a short program that resets the controllers in software. The same program selects the internal temperature sensor, writes a fixed temperature value, and loads the waveform table. A pulse on the other start input runs a full-screen refresh. That sequence programs update control, temperature and the refresh mode, then fires the activation command.

Each command or data byte goes out on a valid/ready byte stream that feeds an SPI byte serializer, together with a flag that separates commands from data. A chip-select output frames every command byte and every run of data bytes. The busy input is active-high. Every wait on it has a limit in milliseconds. When a limit runs out, the block sets a warning flag and goes on with the sequence instead of hanging. All delays are given in milliseconds and scaled by a cycles-per-millisecond parameter.

Top module: `epd_seq_top`

## Requirements
- R1: After reset the outputs are `tx_valid`=0, `cs_n`=1, `panel_rst_n`=1, `done`=0 and `busy_timeout_warn`=0.
- R2: While `tx_valid` is high and `tx_ready` is low, `tx_byte` and `tx_is_data` hold their values. Exactly one byte is transferred per cycle with both high.
- R3: Command bytes carry `tx_is_data`=0 and data bytes carry `tx_is_data`=1. `cs_n` is low while a byte is offered. `cs_n` is high in the cycle after a command byte and after the last data byte of a run. It stays low between consecutive data bytes.
- R4: Bring-up first holds `panel_rst_n` high for at least RST_MS, then low for RST_MS (up to 4 extra cycles), then high again for at least RST_MS before any byte is offered.
- R5: Bring-up sends, as (flag,byte) with C=command and D=data: C 0x12, C 0x18, D 0x80, C 0x22, D 0xB1, C 0x20, C 0x1A, D 0x64, D 0x00, C 0x22, D 0x91, C 0x20.
- R6: After the software-reset command 0x12 and after each activation command 0x20 of bring-up, no further byte is offered for at least ACT_MS (SWRST_MS after 0x12).
- R7: While `panel_busy` is high during a busy wait, no byte and no `done` appear. After it falls, the sequence resumes within 4 cycles.
- R8: If `panel_busy` stays high for the whole limit (BSY_INIT_MS in bring-up, BSY_REFR_MS in refresh), `busy_timeout_warn` is set and the sequence continues. The flag stays set until the next accepted start clears it.
- R9: Refresh sends C 0x21, D 0x40, D 0x10, C 0x1A, D 0x64, D 0x00, C 0x22, D 0xD7, C 0x20. It then waits on busy with limit BSY_REFR_MS.
- R10: `done` is high for exactly one cycle when the selected sequence finishes, and never while a byte is offered.
- R11: A start input that arrives while a sequence runs is ignored. The running stream is unchanged and only one `done` follows.
- R12: If both start inputs rise in the same cycle while idle, bring-up runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_init | input | 1 | Pulse: run bring-up sequence |
| start_refresh | input | 1 | Pulse: run full refresh sequence |
| tx_valid | output | 1 | Byte offered to serializer |
| tx_byte | output | 8 | Byte value |
| tx_is_data | output | 1 | 1 = data byte, 0 = command byte |
| tx_ready | input | 1 | Serializer accepts the byte |
| cs_n | output | 1 | Active-low chip select framing |
| panel_rst_n | output | 1 | Active-low panel hardware reset |
| panel_busy | input | 1 | Active-high panel busy |
| done | output | 1 | One-cycle completion pulse |
| busy_timeout_warn | output | 1 | A busy wait hit its limit |

## Verification
A program counter that skips or repeats a step shows up at once as a wrong or missing byte in the captured stream, or as a changed byte count before `done`. A wrong run-continuation decision appears one cycle after the affected byte, as chip select in the wrong state. A timer that loads the wrong limit only shows up after the wait finishes: the measured gap between two bytes, or between the last byte and `done`, falls outside the expected window. A busy-wait state that ignores the busy input shows up as a byte offered while busy is high, or as a missing warning after the limit.

// File: rtl/epd_seq_pkg.sv
package epd_seq_pkg;
    localparam int ARG_W      = 12;
    localparam int PC_W       = 6;
    localparam int INIT_ENTRY = 0;
    localparam int REFR_ENTRY = 23;

    typedef enum logic [2:0] {
        OP_CMD, OP_DAT, OP_RHI, OP_RLO, OP_DLY, OP_BSY, OP_END
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [ARG_W-1:0] arg;
    } step_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_EXEC, ST_SEND, ST_GAP, ST_HOLD, ST_WAITB
    } st_e;
endpackage

// File: rtl/epd_step_rom.sv
module epd_step_rom
    import epd_seq_pkg::*;
#(
    parameter int RST_MS      = 20,
    parameter int SWRST_MS    = 10,
    parameter int ACT_MS      = 10,
    parameter int BSY_INIT_MS = 100,
    parameter int BSY_REFR_MS = 2500
) (
    input  logic [PC_W-1:0] idx,
    output step_t           cur,
    output logic            nxt_is_dat
);
    function automatic step_t mk(input op_e o, input int a);
        step_t s;
        s.op  = o;
        s.arg = ARG_W'(a);
        return s;
    endfunction

    function automatic step_t entry(input logic [PC_W-1:0] i);
        case (i)
            // bring-up: hardware reset phase
            6'd0:  return mk(OP_RHI, RST_MS);
            6'd1:  return mk(OP_RLO, RST_MS);
            6'd2:  return mk(OP_RHI, RST_MS);
            6'd3:  return mk(OP_BSY, BSY_INIT_MS);
            // software reset
            6'd4:  return mk(OP_CMD, 'h12);
            6'd5:  return mk(OP_DLY, SWRST_MS);
            6'd6:  return mk(OP_BSY, BSY_INIT_MS);
            // sensor select, first table load
            6'd7:  return mk(OP_CMD, 'h18);
            6'd8:  return mk(OP_DAT, 'h80);
            6'd9:  return mk(OP_CMD, 'h22);
            6'd10: return mk(OP_DAT, 'hB1);
            6'd11: return mk(OP_CMD, 'h20);
            6'd12: return mk(OP_DLY, ACT_MS);
            6'd13: return mk(OP_BSY, BSY_INIT_MS);
            // fixed temperature, second table load
            6'd14: return mk(OP_CMD, 'h1A);
            6'd15: return mk(OP_DAT, 'h64);
            6'd16: return mk(OP_DAT, 'h00);
            6'd17: return mk(OP_CMD, 'h22);
            6'd18: return mk(OP_DAT, 'h91);
            6'd19: return mk(OP_CMD, 'h20);
            6'd20: return mk(OP_DLY, ACT_MS);
            6'd21: return mk(OP_BSY, BSY_INIT_MS);
            6'd22: return mk(OP_END, 0);
            // full refresh
            6'd23: return mk(OP_CMD, 'h21);
            6'd24: return mk(OP_DAT, 'h40);
            6'd25: return mk(OP_DAT, 'h10);
            6'd26: return mk(OP_CMD, 'h1A);
            6'd27: return mk(OP_DAT, 'h64);
            6'd28: return mk(OP_DAT, 'h00);
            6'd29: return mk(OP_CMD, 'h22);
            6'd30: return mk(OP_DAT, 'hD7);
            6'd31: return mk(OP_CMD, 'h20);
            6'd32: return mk(OP_BSY, BSY_REFR_MS);
            default: return mk(OP_END, 0);
        endcase
    endfunction

    step_t nxt;
    always_comb begin
        cur        = entry(idx);
        nxt        = entry(idx + PC_W'(1));
        nxt_is_dat = (nxt.op == OP_DAT);
    end
endmodule

// File: rtl/epd_ms_timer.sv
module epd_ms_timer
    import epd_seq_pkg::*;
#(
    parameter int CLK_PER_MS = 125000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [ARG_W-1:0] tgt_ms,
    output logic             expired
);
    localparam int CYC_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CLK_PER_MS - 1);

    typedef struct packed {
        logic [CYC_W-1:0] cyc;
        logic [ARG_W-1:0] ms;
    } tmr_t;

    tmr_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        expired = (r_q.ms == tgt_ms);
        if (clr) begin
            r_d.cyc = '0;
            r_d.ms  = '0;
        end else if (!expired) begin
            if (r_q.cyc == CYC_LAST) begin
                r_d.cyc = '0;
                r_d.ms  = r_q.ms + ARG_W'(1);
            end else begin
                r_d.cyc = r_q.cyc + CYC_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/epd_seq_top.sv
module epd_seq_top
    import epd_seq_pkg::*;
#(
    parameter int CLK_PER_MS  = 125000,
    parameter int RST_MS      = 20,
    parameter int SWRST_MS    = 10,
    parameter int ACT_MS      = 10,
    parameter int BSY_INIT_MS = 100,
    parameter int BSY_REFR_MS = 2500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_init,
    input  logic       start_refresh,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    output logic       tx_is_data,
    input  logic       tx_ready,
    output logic       cs_n,
    output logic       panel_rst_n,
    input  logic       panel_busy,
    output logic       done,
    output logic       busy_timeout_warn
);
    typedef struct packed {
        st_e             st;
        logic [PC_W-1:0] pc;
        logic            prst_n;
        logic            warn;
        logic            done;
    } seq_t;

    seq_t  s_q, s_d;
    step_t cur;
    logic  nxt_is_dat;
    logic  tmr_clr;
    logic  tmr_exp;

    epd_step_rom #(
        .RST_MS(RST_MS), .SWRST_MS(SWRST_MS), .ACT_MS(ACT_MS),
        .BSY_INIT_MS(BSY_INIT_MS), .BSY_REFR_MS(BSY_REFR_MS)
    ) u_rom (
        .idx(s_q.pc), .cur(cur), .nxt_is_dat(nxt_is_dat)
    );

    epd_ms_timer #(.CLK_PER_MS(CLK_PER_MS)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr),
        .tgt_ms(cur.arg), .expired(tmr_exp)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        tmr_clr  = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start_init) begin
                    s_d.pc   = PC_W'(INIT_ENTRY);
                    s_d.warn = 1'b0;
                    s_d.st   = ST_EXEC;
                end else if (start_refresh) begin
                    s_d.pc   = PC_W'(REFR_ENTRY);
                    s_d.warn = 1'b0;
                    s_d.st   = ST_EXEC;
                end
            end
            ST_EXEC: begin
                case (cur.op)
                    OP_CMD, OP_DAT: s_d.st = ST_SEND;
                    OP_RHI: begin
                        s_d.prst_n = 1'b1;
                        tmr_clr    = 1'b1;
                        s_d.st     = ST_HOLD;
                    end
                    OP_RLO: begin
                        s_d.prst_n = 1'b0;
                        tmr_clr    = 1'b1;
                        s_d.st     = ST_HOLD;
                    end
                    OP_DLY: begin
                        tmr_clr = 1'b1;
                        s_d.st  = ST_HOLD;
                    end
                    OP_BSY: begin
                        tmr_clr = 1'b1;
                        s_d.st  = ST_WAITB;
                    end
                    default: begin
                        s_d.done = 1'b1;
                        s_d.st   = ST_IDLE;
                    end
                endcase
            end
            ST_SEND: begin
                if (tx_ready) begin
                    s_d.pc = s_q.pc + PC_W'(1);
                    s_d.st = (cur.op == OP_DAT && nxt_is_dat) ? ST_SEND : ST_GAP;
                end
            end
            ST_GAP: s_d.st = ST_EXEC;
            ST_HOLD: begin
                if (tmr_exp) begin
                    s_d.pc = s_q.pc + PC_W'(1);
                    s_d.st = ST_EXEC;
                end
            end
            ST_WAITB: begin
                if (!panel_busy) begin
                    s_d.pc = s_q.pc + PC_W'(1);
                    s_d.st = ST_EXEC;
                end else if (tmr_exp) begin
                    s_d.warn = 1'b1;
                    s_d.pc   = s_q.pc + PC_W'(1);
                    s_d.st   = ST_EXEC;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st     <= ST_IDLE;
            s_q.pc     <= '0;
            s_q.prst_n <= 1'b1;
            s_q.warn   <= 1'b0;
            s_q.done   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_valid          = (s_q.st == ST_SEND);
    assign tx_byte           = cur.arg[7:0];
    assign tx_is_data        = (cur.op == OP_DAT);
    assign cs_n              = (s_q.st != ST_SEND);
    assign panel_rst_n       = s_q.prst_n;
    assign done              = s_q.done;
    assign busy_timeout_warn = s_q.warn;
endmodule

// File: rtl/epd_seq_chk.sv
module epd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_valid,
    input logic [7:0] tx_byte,
    input logic       tx_is_data,
    input logic       tx_ready,
    input logic       cs_n,
    input logic       panel_rst_n,
    input logic       panel_busy,
    input logic       done,
    input logic       busy_timeout_warn
);
    // R2
    a_r2_hold_stalled_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte) && $stable(tx_is_data)));

    // R3
    a_r3_cmd_releases_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !tx_is_data) |=> cs_n);

    // R4
    a_r4_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !panel_rst_n |-> !tx_valid);

    // R8
    a_r8_warn_only_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_timeout_warn) |-> $past(panel_busy));

    // R10
    a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    a_r10_done_not_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !tx_valid);
endmodule

bind epd_seq_top epd_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_is_data(tx_is_data), .tx_ready(tx_ready), .cs_n(cs_n),
    .panel_rst_n(panel_rst_n), .panel_busy(panel_busy), .done(done),
    .busy_timeout_warn(busy_timeout_warn)
);

// File: tb/epd_seq_top_tb_top.sv
module epd_seq_top_tb_top;
    localparam int CPM   = 4;
    localparam int RMS   = 20;
    localparam int SWMS  = 10;
    localparam int AMS   = 10;
    localparam int BIMS  = 100;
    localparam int BRMS  = 2500;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_init = 1'b0;
    logic       start_refresh = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       tx_is_data;
    logic       tx_ready;
    logic       cs_n;
    logic       panel_rst_n;
    logic       panel_busy = 1'b0;
    logic       done;
    logic       busy_timeout_warn;

    int  cyc = 0;
    bit  rdy_mode = 1'b0;
    int  n_tests = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign tx_ready = rdy_mode ? (cyc[1:0] != 2'd0) : 1'b1;

    epd_seq_top #(
        .CLK_PER_MS(CPM), .RST_MS(RMS), .SWRST_MS(SWMS), .ACT_MS(AMS),
        .BSY_INIT_MS(BIMS), .BSY_REFR_MS(BRMS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_init(start_init),
        .start_refresh(start_refresh), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .tx_is_data(tx_is_data), .tx_ready(tx_ready), .cs_n(cs_n),
        .panel_rst_n(panel_rst_n), .panel_busy(panel_busy), .done(done),
        .busy_timeout_warn(busy_timeout_warn)
    );

    // expected streams: {is_data, byte}
    logic [8:0] exp_init [12] = '{9'h012, 9'h018, 9'h180, 9'h022, 9'h1B1, 9'h020,
                                   9'h01A, 9'h164, 9'h100, 9'h022, 9'h191, 9'h020};
    logic [8:0] exp_refr [9]  = '{9'h021, 9'h140, 9'h110, 9'h01A, 9'h164, 9'h100,
                                   9'h022, 9'h1D7, 9'h020};

    // monitor
    logic [8:0] mb [64];
    int         mcyc [64];
    logic       mcs [64];
    int         nb = 0;
    bit         acc_pend = 0;
    int         ndone = 0;
    int         done_cyc = 0;
    bit         prev_done = 0;
    int         done_long = 0;
    int         fall_cyc = -1;
    int         rise_cyc = -1;
    logic       prev_rst = 1'b1;
    bit         prev_stall = 0;
    logic [8:0] prev_word = '0;
    int         hold_err = 0;
    int         busy_byte = 0;
    int         start_cyc = 0;

    always @(negedge clk) begin
        if (acc_pend) begin
            mcs[nb-1] = cs_n;
            acc_pend  = 0;
        end
        if (prev_stall && (!tx_valid || {tx_is_data, tx_byte} != prev_word)) hold_err++;
        prev_stall = tx_valid && !tx_ready;
        prev_word  = {tx_is_data, tx_byte};
        if (tx_valid && panel_busy) busy_byte++;
        if (tx_valid && tx_ready && nb < 64) begin
            mb[nb]   = {tx_is_data, tx_byte};
            mcyc[nb] = cyc;
            nb++;
            acc_pend = 1;
        end
        if (done) begin
            ndone++;
            done_cyc = cyc;
            if (prev_done) done_long++;
        end
        prev_done = done;
        if (panel_rst_n !== prev_rst) begin
            if (!panel_rst_n) fall_cyc = cyc;
            else              rise_cyc = cyc;
        end
        prev_rst = panel_rst_n;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        nb = 0; acc_pend = 0; ndone = 0; done_long = 0; hold_err = 0;
        fall_cyc = -1; rise_cyc = -1; busy_byte = 0;
    endtask

    task automatic pulse(input bit ini, input bit ref_);
        @(negedge clk);
        start_init = ini; start_refresh = ref_;
        start_cyc = cyc;
        @(negedge clk);
        start_init = 0; start_refresh = 0;
    endtask

    task automatic wait_done(input int lim, input string req);
        int t = 0;
        while (ndone == 0 && t < lim) begin
            @(negedge clk);
            t++;
        end
        chk(ndone != 0, req, "sequence reached done", ndone, 1);
        repeat (3) @(negedge clk);
    endtask

    task automatic cmp_stream(input bit refr, input string req);
        int n = refr ? 9 : 12;
        chk(nb == n, req, "byte count", nb, n);
        for (int i = 0; i < n && i < nb; i++) begin
            logic [8:0] e = refr ? exp_refr[i] : exp_init[i];
            chk(mb[i] == e, req, $sformatf("byte %0d {flag,value}", i), mb[i], e);
        end
    endtask

    task automatic cmp_cs(input bit refr);
        int n = refr ? 9 : 12;
        for (int i = 0; i < n && i < nb; i++) begin
            logic [8:0] e  = refr ? exp_refr[i] : exp_init[i];
            logic [8:0] e2 = (i + 1 < n) ? (refr ? exp_refr[i+1] : exp_init[i+1]) : 9'h000;
            logic expcs = !(e[8] && e2[8]);
            chk(mcs[i] == expcs, "R3", $sformatf("cs_n after byte %0d", i), mcs[i], expcs);
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk(!tx_valid, "R1", "tx_valid", tx_valid, 0);
        chk(cs_n, "R1", "cs_n", cs_n, 1);
        chk(panel_rst_n, "R1", "panel_rst_n", panel_rst_n, 1);
        chk(!done, "R1", "done", done, 0);
        chk(!busy_timeout_warn, "R1", "warn", busy_timeout_warn, 0);
    endtask

    task automatic t_init_plain();
        clear_mon(); rdy_mode = 0; panel_busy = 0;
        pulse(1, 0);
        wait_done(20000, "R5");
        cmp_stream(0, "R5");
        cmp_cs(0);
        chk(fall_cyc - start_cyc >= RMS*CPM, "R4", "first high hold", fall_cyc - start_cyc, RMS*CPM);
        chk(rise_cyc - fall_cyc >= RMS*CPM && rise_cyc - fall_cyc <= RMS*CPM + 4,
            "R4", "low pulse width", rise_cyc - fall_cyc, RMS*CPM);
        chk(mcyc[0] - rise_cyc >= RMS*CPM, "R4", "high hold before bytes", mcyc[0] - rise_cyc, RMS*CPM);
        chk(mcyc[1] - mcyc[0] >= SWMS*CPM, "R6", "gap after 0x12", mcyc[1] - mcyc[0], SWMS*CPM);
        chk(mcyc[6] - mcyc[5] >= AMS*CPM, "R6", "gap after first 0x20", mcyc[6] - mcyc[5], AMS*CPM);
        chk(done_cyc - mcyc[11] >= AMS*CPM, "R6", "gap after last 0x20", done_cyc - mcyc[11], AMS*CPM);
        chk(done_long == 0 && ndone == 1, "R10", "single one-cycle done", ndone, 1);
        chk(!busy_timeout_warn, "R8", "no warn when busy low", busy_timeout_warn, 0);
    endtask

    task automatic t_refresh_stall();
        clear_mon(); rdy_mode = 1; panel_busy = 0;
        pulse(0, 1);
        wait_done(5000, "R9");
        cmp_stream(1, "R9");
        cmp_cs(1);
        chk(hold_err == 0, "R2", "byte held under stall", hold_err, 0);
        chk(ndone == 1 && done_long == 0, "R10", "refresh done pulse", ndone, 1);
        rdy_mode = 0;
    endtask

    task automatic t_busy_release();
        clear_mon(); panel_busy = 1;
        pulse(1, 0);
        while (rise_cyc < 0) @(negedge clk);
        repeat (RMS*CPM + 30*CPM) @(negedge clk);
        chk(nb == 0, "R7", "no byte while busy high", nb, 0);
        @(negedge clk);
        panel_busy = 0;
        repeat (4) @(negedge clk);
        chk(nb == 1 && mb[0] == 9'h012, "R7", "resume after busy falls", nb, 1);
        wait_done(20000, "R7");
        chk(busy_byte == 0, "R7", "bytes offered while busy", busy_byte, 0);
        chk(!busy_timeout_warn, "R7", "no warn on early release", busy_timeout_warn, 0);
    endtask

    task automatic t_init_timeout();
        clear_mon(); panel_busy = 1;
        pulse(1, 0);
        wait_done(20000, "R8");
        panel_busy = 0;
        chk(nb == 12, "R8", "init continues past timeouts", nb, 12);
        chk(mcyc[6] - mcyc[5] >= (AMS + BIMS)*CPM, "R8", "delay+busy limit after 0x20",
            mcyc[6] - mcyc[5], (AMS + BIMS)*CPM);
        chk(busy_timeout_warn, "R8", "warn set after init timeout", busy_timeout_warn, 1);
        repeat (20) @(negedge clk);
        chk(busy_timeout_warn, "R8", "warn held while idle", busy_timeout_warn, 1);
    endtask

    task automatic t_refresh_clears_then_times_out();
        clear_mon(); panel_busy = 0;
        pulse(0, 1);
        wait_done(5000, "R8");
        chk(!busy_timeout_warn, "R8", "warn cleared by new start", busy_timeout_warn, 1'b0);
        clear_mon(); panel_busy = 1;
        pulse(0, 1);
        wait_done(20000, "R8");
        panel_busy = 0;
        chk(done_cyc - mcyc[8] >= BRMS*CPM && done_cyc - mcyc[8] <= BRMS*CPM + 8,
            "R8", "refresh busy limit", done_cyc - mcyc[8], BRMS*CPM);
        chk(busy_timeout_warn, "R8", "warn after refresh timeout", busy_timeout_warn, 1);
        cmp_stream(1, "R9");
    endtask

    task automatic t_ignore_start();
        clear_mon(); panel_busy = 0;
        pulse(1, 0);
        repeat (10) @(negedge clk);
        pulse(0, 1);
        while (nb < 3) @(negedge clk);
        pulse(1, 1);
        wait_done(20000, "R11");
        cmp_stream(0, "R11");
        repeat (50) @(negedge clk);
        chk(ndone == 1, "R11", "only one done", ndone, 1);
        chk(nb == 12, "R11", "no extra bytes after done", nb, 12);
    endtask

    task automatic t_both_start();
        clear_mon(); panel_busy = 0;
        pulse(1, 1);
        wait_done(20000, "R12");
        chk(fall_cyc >= 0, "R12", "reset pulse issued", fall_cyc >= 0, 1);
        chk(nb > 0 && mb[0] == 9'h012, "R12", "first byte is 0x12", mb[0], 9'h012);
        chk(nb == 12, "R12", "bring-up byte count", nb, 12);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_init_plain();
        t_refresh_stall();
        t_busy_release();
        t_init_timeout();
        t_refresh_clears_then_times_out();
        t_ignore_start();
        t_both_start();
        summary();
    end
endmodule